// File: doc/BRIEF.md
# Four-Channel DAC Serial Command Front End

This block is the digital receive side of a four-channel digital-to-analog converter. A host writes 32-bit command frames over a serial peripheral interface while holding the chip select low. The block oversamples the serial clock, chip select and data lines in the system clock domain. It assembles each frame, checks its length when chip select returns high, and then carries out the command. Each frame holds a command field, a channel address and a data field.

Every channel has two stages. The first is an input register that frames load. The second is an output register that drives the converter code. A frame can move a value between the stages, or an active-low hardware load strobe can do it. The block also keeps a two-bit power-down mode per channel, a per-channel mask that shields channels from the hardware strobe, and a flag for the chain mode. A resolution parameter of 12, 14 or 16 bits sets how many data bits are taken from the frame. The data field is always left-justified at bit 19.

Top module: `quad_dac_frontend`

## Requirements
- R1: A frame is sampled on SCLK falling edges while cs_n is low, most significant bit first. It runs only if exactly 32 falling edges occurred before cs_n rose. A shorter or longer frame changes nothing.
- R2: Bits 23:20 hold the address. Values 0 to 3 select that single channel, 15 selects all four channels, and 4 to 14 select no channel.
- R3: Command 3 (bits 27:24) loads the data into both the input register and the output register of each selected channel.
- R4: Command 0 loads only the input register of each selected channel. Command 1 copies the input register into the output register of each selected channel.
- R5: Command 2 loads the input register of each selected channel. It then loads every channel's output register from its input register, and a channel written by the same frame takes the new data.
- R6: Command 4 sets the power-down mode of every channel whose bit in frame bits 3:0 is set to the value of bits 9:8. The modes are 0 normal, 1 low-ohm to ground, 2 high-ohm to ground and 3 high impedance. Writing mode 0 returns a channel to normal.
- R7: Command 5 zeroes all output registers and leaves the input registers unchanged.
- R8: Command 7 and the rst input both zero all input and output registers, set every mode to 0 and clear the strobe mask. rst also clears the chain flag.
- R9: Command 6 stores frame bits 3:0 as the strobe mask. While ldac_n is low, every channel whose mask bit is 0 copies its input register into its output register. Masked channels keep their value.
- R10: Command 8 sets the chain_mode output to 1.
- R11: Commands 9 to 15 change no output and no stored state.
- R12: The data field is frame bits 19 down to 20 minus RES. dac_codes channel c sits at bits c*RES+RES-1 to c*RES, and pd_modes channel c sits at bits 2c+1 to 2c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idles high, data taken on falling edge |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data in |
| ldac_n | input | 1 | Active-low hardware load strobe |
| dac_codes | output | 4*RES | Output register code of each channel |
| pd_modes | output | 8 | Two-bit power-down mode of each channel |
| chain_mode | output | 1 | Chain mode flag |

## Verification
The bench builds two instances that receive the same serial lines: one with RES = 16 and one with RES = 12. The 16-bit instance shows every data bit from bit 19 down to bit 4. The 12-bit instance checks that the data window moves with the parameter and that the lower four bits are dropped. Because every operation copies or zeroes whole codes, each 12-bit expected value is the top 12 bits of the 16-bit expectation. One reference model therefore serves both builds.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  localparam int NUM_CH   = 4;
  localparam int FRAME_W  = 32;
  localparam int CMD_LO   = 24;
  localparam int ADDR_LO  = 20;
  localparam int DATA_MSB = 19;
  localparam int MODE_LO  = 8;
  localparam int MODE_W   = 2;

  typedef enum logic [3:0] {
    OP_WR_IN      = 4'd0,
    OP_UPD        = 4'd1,
    OP_WR_UPD_ALL = 4'd2,
    OP_WR_UPD     = 4'd3,
    OP_PWR        = 4'd4,
    OP_CLR        = 4'd5,
    OP_MASK       = 4'd6,
    OP_SOFT_RST   = 4'd7,
    OP_CHAIN      = 4'd8
  } op_e;

  typedef struct packed {
    logic wr_in;      // load input register from frame data
    logic load_dac;   // load output register
    logic from_data;  // output register source: 1 = frame data, 0 = input register
    logic clr_dac;    // zero output register
    logic zero_all;   // zero everything in the channel
    logic pd_wr;      // load power-down mode
  } ch_ctl_t;

endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import dacfe_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic                  mosi,
  output logic                  frame_vld,
  output logic [FRAME_BITS-1:0] frame
);

  localparam int CNT_W = $clog2(FRAME_BITS + 2) + 1;

  logic [2:0]            sclk_p;
  logic [2:0]            cs_p;
  logic [1:0]            mosi_p;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] shift_q;
  logic                  sclk_fall;
  logic                  cs_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '1;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      cs_p   <= {cs_p[1:0], cs_n};
      mosi_p <= {mosi_p[0], mosi};
    end
  end

  assign sclk_fall = sclk_p[2] & ~sclk_p[1] & ~cs_p[1];
  assign cs_rise   = cs_p[1] & ~cs_p[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      shift_q   <= '0;
      frame_vld <= 1'b0;
    end else begin
      frame_vld <= cs_rise && (bit_cnt == CNT_W'(FRAME_BITS));
      if (cs_p[1]) begin
        bit_cnt <= '0;
      end else if (sclk_fall) begin
        shift_q <= {shift_q[FRAME_BITS-2:0], mosi_p[1]};
        if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign frame = shift_q;

  // R1: a frame of the wrong length never raises the valid pulse
  p_len_r1: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && bit_cnt != CNT_W'(FRAME_BITS)) |=> !frame_vld);

  // R1: a valid pulse lasts one cycle
  p_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    frame_vld |=> !frame_vld);

endmodule

// File: rtl/cmd_ctrl.sv
module cmd_ctrl
  import dacfe_pkg::*;
#(
  parameter int RES = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frame_vld,
  input  logic [FRAME_W-1:0]       frame,
  input  logic                     ldac_act,
  output ch_ctl_t [NUM_CH-1:0]     ctl,
  output logic [RES-1:0]           data,
  output logic [MODE_W-1:0]        pd_val,
  output logic                     chain_q
);

  logic [3:0]        cmd;
  logic [3:0]        addr;
  logic [NUM_CH-1:0] sel;
  logic [NUM_CH-1:0] bit_mask;
  logic [NUM_CH-1:0] mask_q;

  assign cmd      = frame[CMD_LO +: 4];
  assign addr     = frame[ADDR_LO +: 4];
  assign data     = frame[DATA_MSB -: RES];
  assign pd_val   = frame[MODE_LO +: MODE_W];
  assign bit_mask = frame[NUM_CH-1:0];

  always_comb begin
    if (addr == 4'hF)             sel = '1;
    else if (addr[3:2] == 2'b00)  sel = NUM_CH'(1) << addr[1:0];
    else                          sel = '0;
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      ctl[c] = '0;
      if (frame_vld) begin
        case (cmd)
          OP_WR_IN: ctl[c].wr_in = sel[c];
          OP_UPD:   ctl[c].load_dac = sel[c];
          OP_WR_UPD_ALL: begin
            ctl[c].wr_in     = sel[c];
            ctl[c].load_dac  = 1'b1;
            ctl[c].from_data = sel[c];
          end
          OP_WR_UPD: begin
            ctl[c].wr_in     = sel[c];
            ctl[c].load_dac  = sel[c];
            ctl[c].from_data = sel[c];
          end
          OP_PWR:      ctl[c].pd_wr    = bit_mask[c];
          OP_CLR:      ctl[c].clr_dac  = 1'b1;
          OP_SOFT_RST: ctl[c].zero_all = 1'b1;
          default:     ctl[c] = '0;
        endcase
      end else if (ldac_act) begin
        ctl[c].load_dac = ~mask_q[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      chain_q <= 1'b0;
    end else if (frame_vld) begin
      if (cmd == OP_MASK)     mask_q  <= bit_mask;
      if (cmd == OP_SOFT_RST) mask_q  <= '0;
      if (cmd == OP_CHAIN)    chain_q <= 1'b1;
    end
  end

  // R8: the reset command leaves the strobe mask cleared
  p_mask_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && cmd == OP_SOFT_RST) |=> (mask_q == '0));

  // R10: the chain command raises the flag
  p_chain_r10: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && cmd == OP_CHAIN) |=> chain_q);

  // R9: a masked channel never receives a strobe load
  p_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (!frame_vld && ldac_act) |-> ((mask_q & {ctl[3].load_dac, ctl[2].load_dac,
                                             ctl[1].load_dac, ctl[0].load_dac}) == '0));

endmodule

// File: rtl/dac_channel.sv
module dac_channel
  import dacfe_pkg::*;
#(
  parameter int RES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ch_ctl_t           ctl,
  input  logic [RES-1:0]    data,
  input  logic [MODE_W-1:0] pd_val,
  output logic [RES-1:0]    dac_q,
  output logic [MODE_W-1:0] mode_q
);

  logic [RES-1:0] in_q;

  always_ff @(posedge clk) begin
    if (rst || ctl.zero_all) begin
      in_q   <= '0;
      dac_q  <= '0;
      mode_q <= '0;
    end else begin
      if (ctl.wr_in) in_q <= data;
      if (ctl.clr_dac)       dac_q <= '0;
      else if (ctl.load_dac) dac_q <= ctl.from_data ? data : in_q;
      if (ctl.pd_wr) mode_q <= pd_val;
    end
  end

  // R7: clear zeroes the output register
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl.clr_dac && !ctl.zero_all) |=> (dac_q == '0));

  // R8: the reset command zeroes the whole channel
  p_zero_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.zero_all |=> (in_q == '0 && dac_q == '0 && mode_q == '0));

  // R3: a direct load takes the frame data
  p_wr_upd_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl.load_dac && ctl.from_data && !ctl.clr_dac && !ctl.zero_all)
      |=> (dac_q == $past(data)));

  // R6: a power-down write stores the mode field
  p_mode_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl.pd_wr && !ctl.zero_all) |=> (mode_q == $past(pd_val)));

endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend
  import dacfe_pkg::*;
#(
  parameter int RES = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    spi_sclk,
  input  logic                    spi_cs_n,
  input  logic                    spi_mosi,
  input  logic                    ldac_n,
  output logic [NUM_CH*RES-1:0]   dac_codes,
  output logic [MODE_W*NUM_CH-1:0] pd_modes,
  output logic                    chain_mode
);

  logic                 frame_vld;
  logic [FRAME_W-1:0]   frame;
  logic [1:0]           ldac_p;
  logic                 ldac_act;
  ch_ctl_t [NUM_CH-1:0] ctl;
  logic [RES-1:0]       data;
  logic [MODE_W-1:0]    pd_val;

  always_ff @(posedge clk) begin
    if (rst) ldac_p <= '1;
    else     ldac_p <= {ldac_p[0], ldac_n};
  end
  assign ldac_act = ~ldac_p[1];

  spi_frame_rx #(.FRAME_BITS(FRAME_W)) i_rx (
    .clk       (clk),
    .rst       (rst),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .frame_vld (frame_vld),
    .frame     (frame)
  );

  cmd_ctrl #(.RES(RES)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .frame_vld (frame_vld),
    .frame     (frame),
    .ldac_act  (ldac_act),
    .ctl       (ctl),
    .data      (data),
    .pd_val    (pd_val),
    .chain_q   (chain_mode)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dac_channel #(.RES(RES)) i_ch (
      .clk    (clk),
      .rst    (rst),
      .ctl    (ctl[c]),
      .data   (data),
      .pd_val (pd_val),
      .dac_q  (dac_codes[c*RES +: RES]),
      .mode_q (pd_modes[c*MODE_W +: MODE_W])
    );
  end

  // R11: undefined commands leave outputs untouched
  p_ignore_r11: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && frame[CMD_LO +: 4] > 4'd8 && !ldac_act)
      |=> ($stable(dac_codes) && $stable(pd_modes) && $stable(chain_mode)));

endmodule

// File: tb/test_quad_dac_frontend.sv
module test_quad_dac_frontend;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic ldac_n = 1'b1;
  logic [63:0] dac16;
  logic [47:0] dac12;
  logic [7:0]  mode16, mode12;
  logic        chain16, chain12;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  quad_dac_frontend #(.RES(16)) i_quad_dac_frontend (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .ldac_n(ldac_n), .dac_codes(dac16), .pd_modes(mode16), .chain_mode(chain16));

  quad_dac_frontend #(.RES(12)) i_quad_dac_frontend_res12 (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .ldac_n(ldac_n), .dac_codes(dac12), .pd_modes(mode12), .chain_mode(chain12));

  // {req, frame, expected codes ch3..ch0 (16 bit), expected modes ch3..ch0}
  localparam int NV = 17;
  localparam logic [107:0] VEC [NV] = '{
    {4'd3,  32'h0301_2340, 64'h0000_0000_0000_1234, 8'h00}, // R3
    {4'd4,  32'h001A_BCD0, 64'h0000_0000_0000_1234, 8'h00}, // R4
    {4'd4,  32'h0110_0000, 64'h0000_0000_ABCD_1234, 8'h00}, // R4
    {4'd4,  32'h0025_5550, 64'h0000_0000_ABCD_1234, 8'h00}, // R4
    {4'd4,  32'h0037_7770, 64'h0000_0000_ABCD_1234, 8'h00}, // R4
    {4'd5,  32'h0200_F0F0, 64'h7777_5555_ABCD_0F0F, 8'h00}, // R5
    {4'd2,  32'h03F8_0000, 64'h8000_8000_8000_8000, 8'h00}, // R2 all
    {4'd4,  32'h0021_1110, 64'h8000_8000_8000_8000, 8'h00}, // R4
    {4'd7,  32'h0500_0000, 64'h0000_0000_0000_0000, 8'h00}, // R7
    {4'd6,  32'h0400_0105, 64'h0000_0000_0000_0000, 8'h11}, // R6
    {4'd6,  32'h0400_030A, 64'h0000_0000_0000_0000, 8'hDD}, // R6
    {4'd6,  32'h0400_0001, 64'h0000_0000_0000_0000, 8'hDC}, // R6 mode 0
    {4'd11, 32'h09F1_2340, 64'h0000_0000_0000_0000, 8'hDC}, // R11
    {4'd11, 32'h0F3F_FFF0, 64'h0000_0000_0000_0000, 8'hDC}, // R11
    {4'd2,  32'h0170_0000, 64'h0000_0000_0000_0000, 8'hDC}, // R2 no channel
    {4'd4,  32'h0120_0000, 64'h0000_1111_0000_0000, 8'hDC}, // R4
    {4'd9,  32'h0600_0002, 64'h0000_1111_0000_0000, 8'hDC}  // R9 mask
  };

  function automatic logic [47:0] to12(input logic [63:0] v);
    for (int c = 0; c < 4; c++) to12[c*12 +: 12] = v[c*16+4 +: 12];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic [63:0] e16, input logic [7:0] em);
    check(req, dac16, e16);
    check("R12", {16'h0, dac12}, {16'h0, to12(e16)});
    check(req, {56'h0, mode16}, {56'h0, em});
  endtask

  task automatic send(input logic [31:0] f, input int nbits);
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 32) ? f[31-i] : 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk) ldac_n = 1'b0;
    repeat (4) @(negedge clk);
    ldac_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R8: reset state
    check_state("R8", 64'h0, 8'h00);
    check("R10", {63'h0, chain16}, 64'h0);

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][103:72], 32);
      check_state($sformatf("R%0d vec%0d", VEC[v][107:104], v), VEC[v][71:8], VEC[v][7:0]);
    end

    // R9: strobe loads unmasked channels only (ch1 masked)
    strobe();
    check_state("R9", 64'h8000_1111_0000_8000, 8'hDC);

    // R10: chain flag
    send(32'h0800_0000, 32);
    check("R10", {63'h0, chain16}, 64'h1);
    check_state("R10", 64'h8000_1111_0000_8000, 8'hDC);

    // R1: short and long frames are discarded
    send(32'h030A_AAA0, 31);
    check_state("R1", 64'h8000_1111_0000_8000, 8'hDC);
    send(32'h030A_AAA0, 33);
    check_state("R1", 64'h8000_1111_0000_8000, 8'hDC);

    // R8: reset command, then mask and input registers shown cleared
    send(32'h0700_0000, 32);
    check_state("R8", 64'h0, 8'h00);
    send(32'h0014_4440, 32);
    strobe();
    check_state("R8", 64'h0000_0000_4444_0000, 8'h00);

    // R8: reset input
    send(32'h0322_2220, 32);
    check_state("R3", 64'h0000_2222_4444_0000, 8'h00);
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_state("R8", 64'h0, 8'h00);
    check("R8", {63'h0, chain16}, 64'h0);

    finish_run();
  end

endmodule